// File: doc/BRIEF.md
# Bit-Serial Lattice Stage with Distributed Arithmetic

This block is one stage of a lattice FIR filter. The forward and backward prediction samples from the stage before it arrive as serial bit streams, one bit of each per accepted beat. A single signed reflection coefficient is applied to both, and each completed sample yields the stage's two new outputs as parallel words. Each output has its own shift-accumulator. At each bit position the accumulator is addressed by two bits: the current forward bit and the bit of the backward sample delayed by one sample period. Only the coefficient is stored. The unit-weight part of each product term enters the accumulator as a carry term at unit weight, so no four-entry table is kept per output.

Input beats use a valid/ready handshake. A frame-start flag marks bit 0 of every sample. Results leave on a valid/ready handshake. A result that is waiting blocks only the beat that would complete the next sample. The earlier bits of the next sample keep flowing, so a consumer that takes the pending result in the same cycle loses no throughput. Stages are chained into an M-stage filter by re-serialising each stage's outputs for the next stage. Each stage depends only on its own coefficient and the samples it receives.

Top module: `lat_da_cell`

## Requirements
- R1: On each completed sample, `m_f` equals round((f·2^F + k·g')/2^F). Here f is the current forward sample, g' is the backward sample of the previous completed sample, k is `k_coef` read as a signed KW-bit integer, and F = KW-1. Rounding is half-up: add 2^(F-1), then shift right arithmetically by F.
- R2: On each completed sample, `m_g` equals round((g'·2^F + k·f)/2^F), using the same rounding as R1.
- R3: Samples are N-bit two's complement, sent LSB first. Bit N-1 is the sign bit and carries negative weight. A beat is accepted when `s_valid` and `s_ready` are both high. `s_first` high on an accepted beat marks that beat as bit 0.
- R4: After reset, the delayed backward sample g' is zero until the first sample completes.
- R5: A beat with `s_first` high restarts the sample in progress. The interrupted partial sample produces no result and does not replace g'.
- R6: `m_valid` rises in the cycle after the sign-bit beat is accepted. While `m_ready` is low, `m_valid`, `m_f` and `m_g` hold their values.
- R7: `s_ready` is low only when a result is waiting, `m_ready` is low, and the next beat would be bit N-1. Beats that are not accepted change nothing.
- R8: During reset, `m_valid` is low, `m_f` and `m_g` are zero, and `s_ready` is high.
- R9: A new result may load at the same edge where the previous result is taken. Both are delivered, each once.
- R10: With k = -2^(KW-1) (exactly -1), full-scale samples produce the extremes ±(2^N - 1) with no overflow of the (N+1)-bit outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| k_coef | input | KW | Signed reflection coefficient, held stable over each sample |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat ready |
| s_first | input | 1 | Beat is bit 0 of a sample |
| s_f | input | 1 | Forward sample bit |
| s_g | input | 1 | Backward sample bit |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Result taken |
| m_f | output | N+1 | Forward output, signed |
| m_g | output | N+1 | Backward output, signed |

## Verification
Two functions can meet in one cycle: the consumer taking a waiting result, and the acceptance of the sign-bit beat that produces the next result. The bench forces this by holding `m_ready` low after one result. It lets the next sample's first N-1 bits through, and after the stall has lasted a while it raises `m_ready` while the last bit is presented. It checks that `s_ready` stayed low and the held result stayed stable during the stall. It then checks that both results appear in order, each once, with values from the integer model.

// File: rtl/lat_da_pkg.sv
package lat_da_pkg;
  // Path selector for the two accumulators of a stage.
  typedef enum int {
    PATH_FWD = 0,
    PATH_BWD = 1
  } lat_path_e;

  // Accumulator width: N-bit sample times KW-bit coefficient plus the unit term.
  function automatic int acc_width(input int n, input int kw);
    return n + kw + 1;
  endfunction
endpackage

// File: rtl/lat_bit_seq.sv
module lat_bit_seq #(
  parameter int N  = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          first,
  output logic [CW-1:0] idx,
  output logic          sign,
  output logic          last_pend
);
  logic [CW-1:0] cnt;

  assign idx       = first ? '0 : cnt;
  assign sign      = (idx == CW'(N-1));
  assign last_pend = (cnt == CW'(N-1));

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= sign ? '0 : idx + 1'b1;
  end

  // R3: the bit position never leaves the sample
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> idx <= CW'(N-1));
  // R5: a frame-start beat restarts counting from bit 0
  a_r5_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
    adv && first |=> cnt == CW'(1));
endmodule

// File: rtl/lat_g_delay.sv
module lat_g_delay #(
  parameter int N  = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          sign,
  input  logic          g_bit,
  input  logic [CW-1:0] idx,
  output logic          gd_bit
);
  // gcap collects bits 0..N-2 of the sample in flight; gprev holds the
  // last completed sample and is only replaced on its sign beat.
  logic [N-2:0] gcap;
  logic [N-1:0] gprev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcap  <= '0;
      gprev <= '0;
    end else if (adv) begin
      gcap <= {g_bit, gcap[N-2:1]};
      if (sign) gprev <= {g_bit, gcap};
    end
  end

  assign gd_bit = gprev[idx];

  // R5: the delayed sample changes only when a sample completes
  a_r5_gprev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && sign) |=> $stable(gprev));
endmodule

// File: rtl/lat_da_acc.sv
module lat_da_acc #(
  parameter int N  = 8,
  parameter int KW = 8,
  parameter int CW = 3,
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          restart,
  input  logic          sign,
  input  logic [CW-1:0] idx,
  input  logic [KW-1:0] k,
  input  logic          sel_bit,
  input  logic          unit_bit,
  output logic [AW-1:0] sum
);
  localparam int F = KW - 1;

  logic [AW-1:0] acc, kx, coef_part, unit_part, part, base;

  // Only K is stored; the unit weight enters as a carry term at 2^F.
  assign kx        = {{(AW-KW){k[KW-1]}}, k};
  assign coef_part = sel_bit  ? (kx << idx) : '0;
  assign unit_part = unit_bit ? (AW'(1) << (32'(idx) + F)) : '0;
  assign part      = coef_part + unit_part;
  assign base      = restart ? '0 : acc;
  assign sum       = sign ? base - part : base + part;

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (adv) acc <= sum;
  end

  // R7: without an accepted beat the accumulator keeps its value
  a_r7_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc));
  // R5: restarting with an empty address leaves nothing behind
  a_r5_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    adv && restart && !sel_bit && !unit_bit |=> acc == '0);
endmodule

// File: rtl/lat_da_cell.sv
module lat_da_cell #(
  parameter int N  = 8,
  parameter int KW = 8,
  parameter int OW = N + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] k_coef,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_first,
  input  logic          s_f,
  input  logic          s_g,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [OW-1:0] m_f,
  output logic [OW-1:0] m_g
);
  import lat_da_pkg::*;

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam int F  = KW - 1;
  localparam int AW = acc_width(N, KW);
  localparam logic [AW-1:0] HALF = AW'(1) << (F - 1);

  logic          adv, sign, last_pend, gd_bit;
  logic [CW-1:0] idx;
  logic [AW-1:0] psum [2];
  logic [AW-1:0] rsum [2];

  assign s_ready = !(m_valid && !m_ready && last_pend);
  assign adv     = s_valid && s_ready;

  lat_bit_seq #(.N(N), .CW(CW)) i_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .first(s_first),
    .idx(idx), .sign(sign), .last_pend(last_pend)
  );

  lat_g_delay #(.N(N), .CW(CW)) i_gdly (
    .clk(clk), .rst_n(rst_n), .adv(adv), .sign(sign),
    .g_bit(s_g), .idx(idx), .gd_bit(gd_bit)
  );

  // Forward path: K addressed by g', unit by f. Backward path: the reverse.
  for (genvar p = 0; p < 2; p++) begin : g_path
    logic sel, unit;
    assign sel  = (p == int'(PATH_FWD)) ? gd_bit : s_f;
    assign unit = (p == int'(PATH_FWD)) ? s_f    : gd_bit;

    lat_da_acc #(.N(N), .KW(KW), .CW(CW), .AW(AW)) i_acc (
      .clk(clk), .rst_n(rst_n), .adv(adv), .restart(s_first), .sign(sign),
      .idx(idx), .k(k_coef), .sel_bit(sel), .unit_bit(unit), .sum(psum[p])
    );

    assign rsum[p] = psum[p] + HALF;
  end

  logic unused_bits;
  assign unused_bits = ^{rsum[0][F-1:0], rsum[1][F-1:0],
                         rsum[0][AW-1:F+OW], rsum[1][AW-1:F+OW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_f     <= '0;
      m_g     <= '0;
    end else if (adv && sign) begin
      m_valid <= 1'b1;
      m_f     <= rsum[int'(PATH_FWD)][F +: OW];
      m_g     <= rsum[int'(PATH_BWD)][F +: OW];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R6: a waiting result is held unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_f) && $stable(m_g));
  // R6: a result appears only after a sign-bit beat
  a_r6_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(adv && sign));
  // R9: a sign beat is accepted only if the slot is free or being emptied
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    adv && sign |-> !m_valid || m_ready);
endmodule

// File: tb/test_lat_da_cell.sv
module test_lat_da_cell;
  localparam int N = 8, KW = 8, OW = N + 1, F = KW - 1, NV = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, s_valid, s_ready, s_first, s_f, s_g, m_valid, m_ready;
  logic [KW-1:0] k_coef;
  logic signed [OW-1:0] m_f, m_g;

  lat_da_cell #(.N(N), .KW(KW), .OW(OW)) i_lat_da_cell (
    .clk(clk), .rst_n(rst_n), .k_coef(k_coef), .s_valid(s_valid),
    .s_ready(s_ready), .s_first(s_first), .s_f(s_f), .s_g(s_g),
    .m_valid(m_valid), .m_ready(m_ready), .m_f(m_f), .m_g(m_g)
  );

  int n_chk = 0, n_bad = 0, prev_g = 0;
  logic signed [OW-1:0] q_f[$], q_g[$];
  string q_tag[$];

  // f, g, k, idle-gap flag. Rows 4..6 are R10 extremes with k = -1.
  localparam int VEC [NV][4] = '{
    '{0, 0, 0, 0},     '{1, 0, 64, 0},      '{-1, 5, -64, 1},
    '{100, -128, 127, 0}, '{127, 50, -128, 0}, '{-128, 127, -128, 0},
    '{-128, -128, -128, 1}, '{-100, 0, 127, 0}, '{3, -3, 1, 0},
    '{-5, 7, -1, 1},   '{64, -64, 96, 0},   '{-77, 33, -33, 0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Integer reference: round((a*2^F + kk*b) / 2^F), half-up.
  function automatic logic signed [OW-1:0] mdl(input int a, input int kk, input int b);
    longint e;
    e = longint'(a) * (longint'(1) <<< F) + longint'(kk) * longint'(b);
    e = (e + (longint'(1) <<< (F - 1))) >>> F;
    return e[OW-1:0];
  endfunction

  task automatic drive_beat(input bit first, input bit fb, input bit gb, input int k);
    @(negedge clk);
    s_valid = 1'b1; s_first = first; s_f = fb; s_g = gb; k_coef = KW'(k);
    forever begin
      #1;
      if (s_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic send_frame(input int f, input int g, input int k, input bit gap, input string tag);
    q_f.push_back(mdl(f, k, prev_g));
    q_g.push_back(mdl(prev_g, k, f));
    q_tag.push_back(tag);
    prev_g = g;
    for (int b = 0; b < N; b++) begin
      if (gap && b == 3) begin @(negedge clk); s_valid = 1'b0; end
      drive_beat(b == 0, f[b], g[b], k);
    end
    @(negedge clk); s_valid = 1'b0; s_first = 1'b0;
  endtask

  task automatic send_partial(input int f, input int g, input int k, input int nb);
    for (int b = 0; b < nb; b++) drive_beat(b == 0, f[b], g[b], k);
    @(negedge clk); s_valid = 1'b0; s_first = 1'b0;
  endtask

  // Result collector: every handshake is compared against the model queue.
  initial begin
    logic signed [OW-1:0] ef, eg;
    string t;
    forever begin
      @(negedge clk); #2;
      if (rst_n === 1'b1 && m_valid && m_ready) begin
        if (q_f.size() == 0) chk(1'b0, "R5 unexpected result", m_f, 0);
        else begin
          ef = q_f.pop_front(); eg = q_g.pop_front(); t = q_tag.pop_front();
          chk(m_f == ef, {t, " R1 forward"}, m_f, ef);
          chk(m_g == eg, {t, " R2 backward"}, m_g, eg);
        end
      end
    end
  end

  task automatic run_all();
    int pa;
    rst_n = 1'b0; s_valid = 1'b0; s_first = 1'b0; s_f = 1'b0; s_g = 1'b0;
    k_coef = '0; m_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(m_valid == 1'b0, "R8 valid in reset", m_valid, 0);
    chk(s_ready == 1'b1, "R8 ready in reset", s_ready, 1);
    chk(m_f == 0 && m_g == 0, "R8 outputs in reset", m_f, 0);
    rst_n = 1'b1;

    // Table walk; the first row sees g' = 0 (R4), rows with gaps stall mid-sample (R7).
    for (int i = 0; i < NV; i++)
      send_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3] != 0, "R3 R4 R10 table");

    for (int i = 0; i < 40; i++)
      send_frame(int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128,
                 int'($urandom_range(0, 255)) - 128, (i % 3) == 0, "R3 random");

    // R5: an interrupted sample yields nothing and leaves g' alone.
    send_partial(55, 99, 20, 3);
    send_frame(-20, 11, 40, 1'b0, "R5 realign");
    wait (q_f.size() == 0);
    repeat (3) @(negedge clk);

    // R7 / R9: hold a result, let the next sample stall on its sign bit,
    // then release so that take and load fall on the same edge.
    m_ready = 1'b0;
    pa = prev_g;
    send_frame(40, -9, 50, 1'b0, "R6 held");
    fork
      send_frame(-61, 17, -90, 1'b0, "R9 same-edge");
      begin
        repeat (12) @(negedge clk);
        #2;
        chk(s_ready == 1'b0, "R7 sign beat blocked", s_ready, 0);
        chk(m_valid == 1'b1, "R6 valid held", m_valid, 1);
        chk(m_f == mdl(40, 50, pa), "R6 held forward value", m_f, mdl(40, 50, pa));
        @(negedge clk);
        m_ready = 1'b1;
      end
    join
    wait (q_f.size() == 0);
    repeat (5) @(negedge clk);
    #2;
    chk(m_valid == 1'b0, "R9 no duplicate result", m_valid, 0);
    chk(q_f.size() == 0, "R6 all results delivered", q_f.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule